// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the programming word of a frequency synthesizer. The word has a 9-bit feedback divider value, a 2-bit output divider code and a 3-bit test-select field. A word can reach the block by two routes. The first is a set of parallel pins gated by a parallel strobe. The second is a serial port made of a data line, a serial clock and a serial strobe, which feeds a 14-bit shift register. The most significant bit of that shift register drives the test pin.

All pin inputs are asynchronous to the block. Each one passes through a synchronizer and is then edge-detected in the system clock domain, so the serial clock has to run well below the system clock. Each strobe has a level-sensitive transparent phase and an edge-triggered latch. Whichever event comes last sets the active divider values: a parallel load or a serial transfer.

Top module: `synth_divcfg`

## Requirements
- R1: After reset the active values are M = 200, N = 0 and test select = 0, and the shift register is all zeros, so `shift_out_o` is 0.
- R2: While the synchronized parallel strobe is low, `m_o` and `n_o` follow the synchronized `m_pins_i` and `n_pins_i`.
- R3: Whenever the parallel strobe is low, `tsel_o` is driven to 0. Code 0 is the test code that routes the shift register output to the test pin.
- R4: On a rising edge of the parallel strobe, M and N are captured. Later changes on the pins have no effect while the strobe stays high.
- R5: In serial mode (parallel strobe high), each rising edge of the serial clock shifts `ser_data_i` into bit 0 of a 14-bit register. `shift_out_o` is bit 13, the bit clocked in 14 serial clocks earlier. The word is sent test bit 2 first and M bit 0 last.
- R6: A rising edge of the serial strobe in serial mode copies the shift register into the outputs. Bits 13:11 go to `tsel_o`, bits 10:9 go to `n_o` and bits 8:0 go to `m_o`.
- R7: In serial mode with the serial strobe low, the active M, N and test-select values hold. This includes the cycles after the strobe falls and any further serial clocks.
- R8: While the serial strobe is held high in serial mode, each serial clock rise sets `m_o` to the new low 9 bits of the shift register, which are the old bits 7:0 followed by the incoming data bit. N and test select stay unchanged.
- R9: While the parallel strobe is low, serial clocks do not shift the register, so `shift_out_o` keeps its value.
- R10: A change on any pin reaches the outputs on the third system clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| m_pins_i | input | 9 | Parallel feedback divider value |
| n_pins_i | input | 2 | Parallel output divider code |
| par_strobe_i | input | 1 | Parallel strobe: low = transparent, rise = capture |
| ser_data_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial clock, sampled on its rising edge |
| ser_strobe_i | input | 1 | Serial strobe: rise = transfer, high = stream into M |
| m_o | output | 9 | Active feedback divider value |
| n_o | output | 2 | Active output divider code |
| tsel_o | output | 3 | Active test-select code |
| shift_out_o | output | 1 | Oldest shift register bit, for the test pin |

## Verification
The bench builds the block with its default parameters:
- 9-bit M, 2-bit N and 3-bit test fields, giving a 14-bit word;
- two synchronizer stages;
- a reset M of 200.

These values let the bench push whole serial words through. It can then observe the register depth at bit 13 versus bit 14. It can also check the field boundaries at bits 11 and 9 after a transfer, and the two-edge versus three-edge latency that the synchronizers add. The reference model keeps its own history of pin samples and its own shift register. The sequence moves through parallel transparent, parallel latched, serial shift, serial transfer, streaming and hold phases.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int unsigned M_W   = 9;
  localparam int unsigned N_W   = 2;
  localparam int unsigned T_W   = 3;
  localparam int unsigned CFG_W = M_W + N_W + T_W;

  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[i] <= RST;
        else         st_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[i] <= RST;
        else         st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int unsigned W    = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= RST;
    else         lvl_q <= lvl_i;

  for (genvar i = 0; i < W; i++) begin : g_det
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], d_i};

  assign q_o = sr_q;
endmodule

// File: rtl/synth_divcfg.sv
module synth_divcfg
  import divcfg_pkg::*;
#(
  parameter int unsigned    SYNC_STAGES = 2,
  parameter logic [M_W-1:0] M_RESET     = 9'd200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_pins_i,
  input  logic [N_W-1:0] n_pins_i,
  input  logic           par_strobe_i,
  input  logic           ser_data_i,
  input  logic           ser_clk_i,
  input  logic           ser_strobe_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] tsel_o,
  output logic           shift_out_o
);
  localparam int unsigned IN_W = M_W + N_W + 4;
  // parallel strobe idles high so reset does not open the transparent phase
  localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [2:0]      EDGE_RST = 3'b100;

  logic [IN_W-1:0] raw, in_s;
  logic [M_W-1:0]  m_s;
  logic [N_W-1:0]  n_s;
  logic            par_s, sstr_s, sclk_s, sdat_s;
  logic            par_rise, sstr_rise, sclk_rise;
  logic [2:0]      rise_v;
  logic [CFG_W-1:0] sr_q;
  logic            shift_en;
  cfg_word_t       cfg_q, cfg_d, sr_w;

  assign raw = {par_strobe_i, ser_strobe_i, ser_clk_i, ser_data_i, n_pins_i, m_pins_i};

  divcfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (in_s)
  );

  assign {par_s, sstr_s, sclk_s, sdat_s, n_s, m_s} = in_s;

  divcfg_edge #(.W(3), .RST(EDGE_RST)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({par_s, sstr_s, sclk_s}),
    .rise_o(rise_v)
  );

  assign {par_rise, sstr_rise, sclk_rise} = rise_v;

  assign shift_en = par_s & sclk_rise;

  divcfg_shift #(.W(CFG_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .d_i   (sdat_s),
    .q_o   (sr_q)
  );

  assign sr_w = cfg_word_t'(sr_q);

  always_comb begin
    cfg_d = cfg_q;
    if (!par_s || par_rise) begin
      cfg_d.m    = m_s;
      cfg_d.n    = n_s;
      cfg_d.tsel = '0;
    end else if (sstr_rise) begin
      cfg_d = sr_w;
    end else if (sstr_s && sclk_rise) begin
      // stream: M tracks the low field of the register being shifted
      cfg_d.m = {sr_q[M_W-2:0], sdat_s};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q.m    <= M_RESET;
      cfg_q.n    <= '0;
      cfg_q.tsel <= '0;
    end else begin
      cfg_q <= cfg_d;
    end

  assign m_o         = cfg_q.m;
  assign n_o         = cfg_q.n;
  assign tsel_o      = cfg_q.tsel;
  assign shift_out_o = sr_q[CFG_W-1];
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
  import divcfg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             par_s,
  input logic             par_rise,
  input logic             sstr_s,
  input logic             sstr_rise,
  input logic             sclk_rise,
  input logic             sdat_s,
  input logic [M_W-1:0]   m_s,
  input logic [N_W-1:0]   n_s,
  input logic [CFG_W-1:0] sr_q,
  input logic [M_W-1:0]   m_o,
  input logic [N_W-1:0]   n_o,
  input logic [T_W-1:0]   tsel_o,
  input logic             shift_out_o
);
  // R2
  par_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |=> (m_o == $past(m_s)) && (n_o == $past(n_s)));

  // R3
  par_tsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |=> tsel_o == '0);

  // R5
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && sclk_rise) |=> sr_q[0] == $past(sdat_s));

  // R6
  ser_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !par_rise && sstr_rise) |=> {tsel_o, n_o, m_o} == $past(sr_q));

  // R7
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !par_rise && !sstr_s) |=> $stable({tsel_o, n_o, m_o}));

  // R8
  ser_stream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !par_rise && sstr_s && !sstr_rise && sclk_rise)
      |=> (m_o[0] == $past(sdat_s)) && $stable(n_o) && $stable(tsel_o));

  // R9
  par_noshift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |=> $stable(shift_out_o));
endmodule

bind synth_divcfg divcfg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_s      (par_s),
  .par_rise   (par_rise),
  .sstr_s     (sstr_s),
  .sstr_rise  (sstr_rise),
  .sclk_rise  (sclk_rise),
  .sdat_s     (sdat_s),
  .m_s        (m_s),
  .n_s        (n_s),
  .sr_q       (sr_q),
  .m_o        (m_o),
  .n_o        (n_o),
  .tsel_o     (tsel_o),
  .shift_out_o(shift_out_o)
);

// File: tb/synth_divcfg_tb.sv
`timescale 1ns/1ps
module synth_divcfg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_pins = '0;
  logic [1:0] n_pins = '0;
  logic       par = 1'b1, sdat = 1'b0, sclk = 1'b0, sstr = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       so;

  int checks = 0, fails = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  synth_divcfg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .m_pins_i(m_pins), .n_pins_i(n_pins),
    .par_strobe_i(par), .ser_data_i(sdat), .ser_clk_i(sclk), .ser_strobe_i(sstr),
    .m_o(m_o), .n_o(n_o), .tsel_o(t_o), .shift_out_o(so)
  );

  // reference model: pin history delayed by the synchronizers
  typedef struct { bit p, ss, sc, sd; bit [8:0] m; bit [1:0] n; } smp_t;
  smp_t hist [4];
  bit [8:0]  md_m;
  bit [1:0]  md_n;
  bit [2:0]  md_t;
  bit [13:0] md_sr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = '{p:1, ss:0, sc:0, sd:0, m:0, n:0};
      md_m = 9'd200; md_n = 0; md_t = 0; md_sr = 0;
    end else begin
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = '{p:par, ss:sstr, sc:sclk, sd:sdat, m:m_pins, n:n_pins};
      begin
        smp_t c, pv;
        bit crise;
        c = hist[2]; pv = hist[3];
        crise = c.sc && !pv.sc;
        if (!c.p || !pv.p) begin
          md_m = c.m; md_n = c.n; md_t = 0;
        end else if (c.ss && !pv.ss) begin
          md_t = md_sr[13:11]; md_n = md_sr[10:9]; md_m = md_sr[8:0];
        end else if (c.ss && crise) begin
          md_m = {md_sr[7:0], c.sd};
        end
        if (c.p && crise) md_sr = {md_sr[12:0], c.sd};
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) chk({phase, " model"}, {so, t_o, n_o, m_o}, {md_sr[13], md_t, md_n, md_m});

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdat = b; step(3);
    sclk = 1'b1; step(3);
    sclk = 1'b0; step(3);
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 m", m_o, 200); chk("R1 n", n_o, 0); chk("R1 t", t_o, 0); chk("R1 so", so, 0);

    phase = "R2";
    par = 1'b0; m_pins = 9'd150; n_pins = 2'd1;
    step(4);
    chk("R2 m", m_o, 150); chk("R2 n", n_o, 1); chk("R3 t", t_o, 0);

    phase = "R10";
    m_pins = 9'd301; n_pins = 2'd3;
    step(2); chk("R10 early", m_o, 150);
    step(1); chk("R10 m", m_o, 301); chk("R10 n", n_o, 3);

    phase = "R4";
    par = 1'b1; step(4);
    m_pins = 9'd77; n_pins = 2'd0;
    step(5); chk("R4 m", m_o, 301); chk("R4 n", n_o, 3);

    phase = "R5";
    for (int i = 13; i >= 1; i--) send_bit(((14'b101_10_101011001) >> i) & 1);
    chk("R5 depth13", so, 0);
    send_bit(1'b1);
    chk("R5 depth14", so, 1); chk("R7 hold m", m_o, 301);

    phase = "R6";
    sstr = 1'b1; step(4);
    chk("R6 t", t_o, 5); chk("R6 n", n_o, 2); chk("R6 m", m_o, 345);
    phase = "R7";
    sstr = 1'b0; step(4);
    chk("R7 fall", m_o, 345);
    send_word({3'b011, 2'b01, 9'd10});
    chk("R7 m", m_o, 345); chk("R7 t", t_o, 5);

    phase = "R8";
    sstr = 1'b1; step(4);
    chk("R6 t2", t_o, 3); chk("R6 n2", n_o, 1); chk("R6 m2", m_o, 10);
    send_bit(1'b0);
    chk("R8 first", m_o, 20);
    for (int i = 7; i >= 0; i--) send_bit(((9'd171) >> i) & 1);
    chk("R8 m", m_o, 171); chk("R8 n", n_o, 1); chk("R8 t", t_o, 3);

    phase = "R7";
    sstr = 1'b0; step(4);
    send_bit(1'b1); send_bit(1'b1);
    chk("R7 after stream", m_o, 171); chk("R5 so", so, 0);

    phase = "R9";
    par = 1'b0; m_pins = 9'd5; n_pins = 2'd2; step(4);
    send_bit(1'b1);
    chk("R9 so", so, 0); chk("R3 t", t_o, 0); chk("R2 m", m_o, 5); chk("R2 n", n_o, 2);

    finish_run();
  end
endmodule